// File: doc/BRIEF.md
# Lockable Serial Number Register Bank

This block keeps a 64-bit user serial number as eight byte-wide registers on a simple register bus, together with a control register that carries a one-way lock bit. Until the lock is set, software may rewrite the serial bytes as often as it likes and use them as general-purpose storage. Once the lock is set, writes to the serial bytes have no effect and no software write can clear the lock. The stored values can still be read back.

All state is kept in flip-flops and is cleared only by the synchronous, active-low power-on reset. Each bus access lasts one cycle. A read returns its data in the cycle after `rd_en` is sampled. A write to a locked byte is refused and is reported by a one-cycle pulse.

Top module: `sernum_bank`

## Requirements
- R1: While `rst_n` is low at a clock edge, all eight serial bytes and the whole control register (lock included) clear to 0x00, and `rdata` and `write_rejected` become 0.
- R2: Serial byte k (k = 0..7) sits at address 0x11 + k. While unlocked, a write stores `wdata` into that byte, and the byte can be rewritten any number of times.
- R3: A read sampled at edge t presents the addressed value on `rdata` after edge t. In a cycle where no read was sampled, `rdata` is 0x00.
- R4: The control register is at address 0x0B. A write sets bits 6:0 to `wdata[6:0]`. Bit 7 (the lock) becomes its current value OR `wdata[7]`.
- R5: Once the lock is 1, it stays 1 until reset, whatever is written to 0x0B.
- R6: While the lock is 1, writes to 0x11..0x18 leave every serial byte unchanged.
- R7: While the lock is 1, reads of 0x11..0x18 still return the stored bytes.
- R8: A read of any address other than 0x0B and 0x11..0x18 returns 0x00. A write to such an address changes no register.
- R9: `write_rejected` is high for exactly the one cycle after a write to 0x11..0x18 is sampled while the lock is 1. It is 0 after every other access.
- R10: A read and a write to the same address in the same cycle return the value held before the write.
- R11: A write that sets the lock takes effect for serial-byte writes sampled from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe, sampled at the clock edge |
| rdata | output | 8 | Read data, valid the cycle after the read |
| write_rejected | output | 1 | One-cycle pulse after a refused write to a locked byte |

## Verification
A serial byte that holds a wrong value is seen at the ports only when that byte is next read. The bench therefore reads back densely between writes, so a bad value shows up within a few operations. A lock bit that is wrong appears at once: the next write to a serial byte shows it through `write_rejected`, and so does a later read of 0x0B bit 7. A decode error shows up within one cycle as nonzero data from an address outside the window, or as a byte landing in the wrong slot. A reference model checks every cycle under random traffic, both before and after the lock is set.

// File: rtl/sn_pkg.sv
// Shared types for the serial number register bank.
// Assumes: address decode yields one of three targets per access.
package sn_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_SN   = 2'd2
    } sel_e;
endpackage

// File: rtl/sn_decode.sv
// Address decoder: classifies an address as control register, serial byte
// (with its index) or outside the window.
// Assumes: the serial window does not overlap the control address.
module sn_decode
    import sn_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SN_BYTES  = 8,
    parameter int SN_BASE   = 'h11,
    parameter int CTRL_ADDR = 'h0B,
    localparam int IDX_W    = $clog2(SN_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(SN_BASE);
    localparam logic [ADDR_W-1:0] CTRL_V = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W:0]   END_V  = (ADDR_W+1)'(SN_BASE + SN_BYTES);

    logic [ADDR_W-1:0] offset;

    // Classify the address and derive the byte index inside the window.
    always_comb begin
        offset = addr - BASE_V;
        idx    = offset[IDX_W-1:0];
        if (addr == CTRL_V)
            sel = SEL_CTRL;
        else if ((addr >= BASE_V) && ({1'b0, addr} < END_V))
            sel = SEL_SN;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/sn_ctrl_reg.sv
// Control register: plain bits plus a sticky lock bit that only reset clears.
// Assumes: synchronous active-low reset; we is already address-qualified.
module sn_ctrl_reg #(
    parameter int DW       = 8,
    parameter int LOCK_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q,
    output logic          lock
);
    localparam logic [DW-1:0] LMASK = DW'(1) << LOCK_BIT;

    // Store written bits; keep the lock bit once it is set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= wdata | (q & LMASK);
    end

    assign lock = q[LOCK_BIT];

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R4
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q & ~LMASK) == ($past(wdata) & ~LMASK));
endmodule

// File: rtl/sn_byte_bank.sv
// Bank of serial bytes with write gating by the lock and a rejection pulse.
// Assumes: we/idx come from the decoder; lock is the current lock state.
module sn_byte_bank #(
    parameter int DW       = 8,
    parameter int SN_BYTES = 8,
    localparam int IDX_W   = $clog2(SN_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [IDX_W-1:0]             idx,
    input  logic [DW-1:0]                wdata,
    input  logic                         lock,
    output logic [SN_BYTES-1:0][DW-1:0]  bytes_q,
    output logic                         rejected
);
    for (genvar k = 0; k < SN_BYTES; k++) begin : g_byte
        logic hit;
        assign hit = we && !lock && (idx == IDX_W'(k));

        // Hold one serial byte; load it on an unlocked write to its index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bytes_q[k] <= '0;
            else if (hit)
                bytes_q[k] <= wdata;
        end

        // R6
        locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lock && we) |=> $stable(bytes_q[k]));

        // R2
        unlocked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!lock && we && idx == IDX_W'(k)) |=> bytes_q[k] == $past(wdata));
    end

    // Flag a write attempt that the lock refused, for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rejected <= 1'b0;
        else
            rejected <= we && lock;
    end

    // R9
    reject_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && lock) |=> rejected);

    // R9
    reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && lock) |=> !rejected);
endmodule

// File: rtl/sn_rd_port.sv
// Registered read port: selects control or serial data, zero elsewhere.
// Assumes: rdata is 0 in any cycle without a sampled read.
module sn_rd_port
    import sn_pkg::*;
#(
    parameter int DW       = 8,
    parameter int SN_BYTES = 8,
    localparam int IDX_W   = $clog2(SN_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_en,
    input  sel_e                        sel,
    input  logic [IDX_W-1:0]            idx,
    input  logic [SN_BYTES-1:0][DW-1:0] bytes_q,
    input  logic [DW-1:0]               ctrl_q,
    output logic [DW-1:0]               rdata
);
    logic [DW-1:0] mux_d;

    // Pick the source for the addressed register.
    always_comb begin
        case (sel)
            SEL_CTRL: mux_d = ctrl_q;
            SEL_SN:   mux_d = bytes_q[idx];
            default:  mux_d = '0;
        endcase
    end

    // Capture the read result; drive zero when no read was sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_en ? mux_d : '0;
    end

    // R8
    outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> rdata == '0);

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);
endmodule

// File: rtl/sernum_bank.sv
// Top: lockable 64-bit serial number register bank on a simple register bus.
// Assumes: one access per cycle, synchronous active-low power-on reset.
module sernum_bank
    import sn_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DW        = 8,
    parameter int SN_BYTES  = 8,
    parameter int SN_BASE   = 'h11,
    parameter int CTRL_ADDR = 'h0B,
    parameter int LOCK_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DW-1:0]     rdata,
    output logic              write_rejected
);
    localparam int IDX_W = $clog2(SN_BYTES);

    sel_e                        sel;
    logic [IDX_W-1:0]            idx;
    logic [DW-1:0]               ctrl_q;
    logic                        lock;
    logic [SN_BYTES-1:0][DW-1:0] bytes_q;
    logic                        ctrl_we;
    logic                        sn_we;

    sn_decode #(
        .ADDR_W(ADDR_W), .SN_BYTES(SN_BYTES),
        .SN_BASE(SN_BASE), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .addr(addr), .sel(sel), .idx(idx)
    );

    assign ctrl_we = wr_en && (sel == SEL_CTRL);
    assign sn_we   = wr_en && (sel == SEL_SN);

    sn_ctrl_reg #(.DW(DW), .LOCK_BIT(LOCK_BIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(wdata),
        .q(ctrl_q), .lock(lock)
    );

    sn_byte_bank #(.DW(DW), .SN_BYTES(SN_BYTES)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(sn_we), .idx(idx), .wdata(wdata),
        .lock(lock), .bytes_q(bytes_q), .rejected(write_rejected)
    );

    sn_rd_port #(.DW(DW), .SN_BYTES(SN_BYTES)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel), .idx(idx),
        .bytes_q(bytes_q), .ctrl_q(ctrl_q), .rdata(rdata)
    );

    // R8
    outside_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> ($stable(bytes_q) && $stable(ctrl_q)));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0 && !write_rejected && !lock));
endmodule

// File: tb/sernum_bank_tb.sv
module sernum_bank_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       write_rejected;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] m_sn [8];
    logic [7:0] m_ctrl;

    sernum_bank u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .write_rejected(write_rejected)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit in_sn(input logic [7:0] a);
        return (a >= 8'h11) && (a <= 8'h18);
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'h0B) return m_ctrl;
        if (in_sn(a))   return m_sn[a - 8'h11];
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive, clock, compare outputs, then update model.
    task automatic op(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d);
        logic [7:0] exp_rd;
        logic       exp_rej;
        string      tag;
        exp_rd  = r ? model_read(a) : 8'h00;   // R10: read sees pre-write value
        exp_rej = w && in_sn(a) && m_ctrl[7];
        if (!r)                 tag = "R3";
        else if (a == 8'h0B)    tag = "R4";
        else if (in_sn(a))      tag = m_ctrl[7] ? "R7" : "R2";
        else                    tag = "R8";
        addr = a; wdata = d; wr_en = w; rd_en = r;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
        chk(tag, rdata, exp_rd);
        chk("R9", {7'b0, write_rejected}, {7'b0, exp_rej});
        if (w) begin
            if (a == 8'h0B)               m_ctrl = d | (m_ctrl & 8'h80);
            else if (in_sn(a) && !m_ctrl[7]) m_sn[a - 8'h11] = d;
        end
    endtask

    function automatic logic [7:0] rand_addr();
        int unsigned s;
        logic [7:0] a;
        s = $urandom % 8;
        if (s < 5) return 8'h11 + 8'($urandom % 8);
        if (s == 5) return 8'h0B;
        if (s == 6) return ($urandom % 2) ? 8'h10 : 8'h19;
        a = 8'($urandom);
        while (in_sn(a) || a == 8'h0B) a = 8'($urandom);
        return a;
    endfunction

    initial begin
        #(200000 * CLK_PERIOD);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        for (int i = 0; i < 8; i++) m_sn[i] = 8'h00;
        m_ctrl = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", rdata, 8'h00);
        chk("R1", {7'b0, write_rejected}, 8'h00);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) op(0, 1, 8'h11 + 8'(i), 8'h00);  // R1 bytes zero
        op(0, 1, 8'h0B, 8'h00);

        // R2: fill and rewrite each byte
        for (int i = 0; i < 8; i++) op(1, 0, 8'h11 + 8'(i), 8'hA0 + 8'(i));
        for (int i = 0; i < 8; i++) op(1, 1, 8'h11 + 8'(i), 8'h5A ^ 8'(i)); // R10
        for (int i = 0; i < 8; i++) op(0, 1, 8'h11 + 8'(i), 8'h00);
        // R8: write outside window, then read everything
        op(1, 0, 8'h10, 8'hFF); op(1, 0, 8'h19, 8'hFF); op(1, 0, 8'h0C, 8'hFF);
        for (int i = 0; i < 8; i++) op(0, 1, 8'h11 + 8'(i), 8'h00);
        op(0, 1, 8'h0B, 8'h00); op(0, 1, 8'h10, 8'h00); op(0, 1, 8'hFF, 8'h00);

        // Random unlocked phase (lock bit masked off)
        for (int i = 0; i < 800; i++) begin
            logic [7:0] a;
            logic [7:0] d;
            a = rand_addr(); d = 8'($urandom);
            if (a == 8'h0B) d[7] = 1'b0;
            op(bit'($urandom % 2), bit'($urandom % 2), a, d);
        end

        // R11: set lock, then write a byte on the very next cycle
        op(1, 0, 8'h0B, 8'h83);
        op(1, 0, 8'h14, 8'hEE);         // rejected, R9/R6
        op(0, 1, 8'h14, 8'h00);         // R7 value unchanged
        // R5: try to clear the lock
        op(1, 0, 8'h0B, 8'h00);
        op(0, 1, 8'h0B, 8'h00);         // R4/R5: bit7 still 1, low bits 0
        op(1, 1, 8'h0B, 8'h7F);
        op(0, 1, 8'h0B, 8'h00);

        // Random locked phase
        for (int i = 0; i < 800; i++)
            op(bit'($urandom % 2), bit'($urandom % 2), rand_addr(), 8'($urandom));
        for (int i = 0; i < 8; i++) op(0, 1, 8'h11 + 8'(i), 8'h00); // R6/R7

        // R1: reset clears the lock again
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) m_sn[i] = 8'h00;
        m_ctrl = 8'h00;
        op(0, 1, 8'h0B, 8'h00);
        op(1, 0, 8'h11, 8'h3C);
        op(0, 1, 8'h11, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule